// File: doc/BRIEF.md
# Sample Averaging and Output Word Formatter

This block sits between a converter's result path and a serial output shifter. Each accepted 16-bit conversion result is added into an accumulator, together with the 4-bit channel number that produced it. A 3-bit ratio code n sets the window length to 2^n samples. When a window completes, the sum is shifted right by n and the 16-bit average is presented as one output word.

The output word is 20 bits: the 16-bit data field in the upper bits and a 4-bit tag nibble in the lowest bits. A 2-bit append selector decides whether the tag carries the channel number of the last sample in the window, the status flags present with that sample, or nothing. A debug enable replaces the data field with a constant pattern so that a host can check the serial link. A one-cycle valid strobe and a tag-present flag go with the word. The shifter uses the flag to choose between 16 and 20 bits.

Top module: `avg_word_fmt`

## Requirements
- R1: With ratio code 0, every accepted sample gives a valid output in the next cycle. Its data field `outWord[19:4]` equals the sample value.
- R2: With ratio code n, exactly one output is produced per 2^n accepted samples. Its data field is the sum of those samples divided by 2^n, rounded down. No output appears before the window's last sample.
- R3: A full 128-sample window of 0xFFFF yields 0xFFFF. The sum does not overflow.
- R4: While `fixPattern` is 1 when a window completes, the data field is 0xA5A5 whatever the samples were.
- R5: With append selector 01, `outHasTag` is 1 and `outWord[3:0]` is the channel number given with the window's last sample.
- R6: With append selector 10, `outHasTag` is 1 and `outWord[3:0]` is the `statusFlags` value given with the window's last sample.
- R7: With append selector 00 or 11, `outHasTag` is 0 and `outWord[3:0]` is 0.
- R8: A change of the ratio code discards the partial window. The count restarts, and the next window uses only samples that arrive after the change.
- R9: After reset, `outValid` is 0 and `outWord` is 0. `outValid` is high for one cycle only, in the cycle after a window's last sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A conversion result is offered this cycle |
| sampleData | input | 16 | Conversion result |
| sampleChan | input | 4 | Channel number of the result |
| statusFlags | input | 4 | Status nibble that can be appended to the output |
| ratioCode | input | 3 | Window length code; the window is 2^code samples |
| fixPattern | input | 1 | Replace the data field with 0xA5A5 |
| appendMode | input | 2 | Tag select: 01 = channel, 10 = status, 00 and 11 = none |
| outValid | output | 1 | One-cycle strobe marking a new output word |
| outWord | output | 20 | Data field in bits 19:4, tag nibble in bits 3:0 |
| outHasTag | output | 1 | The tag nibble is meaningful |

## Verification
The hardest case to reach is a ratio change in the middle of a window. The first samples must be sent, the code changed during an idle cycle, and the design must then emit only after a full window of new samples, with an average that leaves out the old ones. The bench fills part of an 8-sample window, switches to a 2-sample window, and checks that no word appears after the first new sample. It then checks that the next word is the mean of the two new samples. The full 128-sample window of maximum values is driven as well, because it is the only case that exposes a too-narrow sum.

// File: rtl/avgfmt_pkg.sv
package avgfmt_pkg;
  typedef struct packed {
    logic restart;
    logic take;
    logic first;
    logic last;
  } ctl_t;
endpackage

// File: rtl/avgfmt_ctrl.sv
module avgfmt_ctrl
  import avgfmt_pkg::*;
#(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [RATIO_W-1:0] ratioCode,
  output ctl_t               ctl
);
  localparam int CNT_W = (1 << RATIO_W) - 1;

  logic [RATIO_W-1:0] ratioQ;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cntBase;
  logic [CNT_W-1:0]   lenM1;
  logic [CNT_W-1:0]   lenM1Q;

  always_comb begin
    lenM1      = CNT_W'((CNT_W+1)'(1) << ratioCode) - CNT_W'(1);
    lenM1Q     = CNT_W'((CNT_W+1)'(1) << ratioQ) - CNT_W'(1);
    ctl.restart = (ratioCode != ratioQ);
    cntBase    = ctl.restart ? '0 : cnt;
    ctl.take   = sampleValid;
    ctl.first  = sampleValid && (cntBase == '0);
    ctl.last   = sampleValid && (cntBase == lenM1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ratioQ <= '0;
      cnt    <= '0;
    end else begin
      ratioQ <= ratioCode;
      if (sampleValid)
        cnt <= ctl.last ? '0 : cntBase + CNT_W'(1);
      else if (ctl.restart)
        cnt <= '0;
    end
  end

  // R1: code 0 makes every sample close its window
  p_passthru_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && ratioCode == '0) |-> ctl.last);

  // R2: the count stays inside the window it was started under
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lenM1Q);

  // R8: a ratio change with no sample leaves the count at zero
  p_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.restart && !sampleValid) |=> (cnt == '0));
endmodule

// File: rtl/avgfmt_datapath.sv
module avgfmt_datapath
  import avgfmt_pkg::*;
#(
  parameter int          DATA_W  = 16,
  parameter int          TAG_W   = 4,
  parameter int          RATIO_W = 3,
  parameter logic [15:0] PATTERN = 16'hA5A5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctl_t                    ctl,
  input  logic [DATA_W-1:0]       sampleData,
  input  logic [TAG_W-1:0]        sampleChan,
  input  logic [TAG_W-1:0]        statusFlags,
  input  logic [RATIO_W-1:0]      ratioCode,
  input  logic                    fixPattern,
  input  logic [1:0]              appendMode,
  output logic                    outValid,
  output logic [DATA_W+TAG_W-1:0] outWord,
  output logic                    outHasTag
);
  localparam int MAX_LOG = (1 << RATIO_W) - 1;
  localparam int ACC_W   = DATA_W + MAX_LOG;

  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  sumNext;
  logic [ACC_W-1:0]  shifted;
  logic [DATA_W-1:0] dataField;
  logic [TAG_W-1:0]  tagField;
  logic              tagOn;

  always_comb begin
    sumNext   = (ctl.first ? '0 : acc) + ACC_W'(sampleData);
    shifted   = sumNext >> ratioCode;
    dataField = fixPattern ? DATA_W'(PATTERN) : shifted[DATA_W-1:0];
    unique case (appendMode)
      2'b01:   begin tagField = sampleChan;  tagOn = 1'b1; end
      2'b10:   begin tagField = statusFlags; tagOn = 1'b1; end
      default: begin tagField = '0;          tagOn = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      outValid  <= 1'b0;
      outWord   <= '0;
      outHasTag <= 1'b0;
    end else begin
      if (ctl.take)
        acc <= ctl.last ? '0 : sumNext;
      else if (ctl.restart)
        acc <= '0;
      outValid <= ctl.take && ctl.last;
      if (ctl.take && ctl.last) begin
        outWord   <= {dataField, tagField};
        outHasTag <= tagOn;
      end
    end
  end

  // R9: a word only follows an accepted sample
  p_valid_after_sample_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(ctl.take));

  // R7: no tag means an empty nibble
  p_empty_tag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outHasTag) |-> (outWord[TAG_W-1:0] == '0));
endmodule

// File: rtl/avg_word_fmt.sv
module avg_word_fmt
  import avgfmt_pkg::*;
#(
  parameter int          DATA_W  = 16,
  parameter int          TAG_W   = 4,
  parameter int          RATIO_W = 3,
  parameter logic [15:0] PATTERN = 16'hA5A5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleValid,
  input  logic [DATA_W-1:0]       sampleData,
  input  logic [TAG_W-1:0]        sampleChan,
  input  logic [TAG_W-1:0]        statusFlags,
  input  logic [RATIO_W-1:0]      ratioCode,
  input  logic                    fixPattern,
  input  logic [1:0]              appendMode,
  output logic                    outValid,
  output logic [DATA_W+TAG_W-1:0] outWord,
  output logic                    outHasTag
);
  ctl_t ctl;

  avgfmt_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .ratioCode(ratioCode), .ctl(ctl)
  );

  avgfmt_datapath #(.DATA_W(DATA_W), .TAG_W(TAG_W), .RATIO_W(RATIO_W),
                    .PATTERN(PATTERN)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleData(sampleData),
    .sampleChan(sampleChan), .statusFlags(statusFlags), .ratioCode(ratioCode),
    .fixPattern(fixPattern), .appendMode(appendMode), .outValid(outValid),
    .outWord(outWord), .outHasTag(outHasTag)
  );
endmodule

// File: tb/avg_word_fmt_tb.sv
module avg_word_fmt_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleData = '0;
  logic [3:0]  sampleChan = '0;
  logic [3:0]  statusFlags = '0;
  logic [2:0]  ratioCode = '0;
  logic        fixPattern = 1'b0;
  logic [1:0]  appendMode = '0;
  logic        outValid;
  logic [19:0] outWord;
  logic        outHasTag;

  int nChecks = 0;
  int nFails = 0;
  logic        gotValid;
  logic [19:0] gotWord;
  logic        gotTag;

  always #4 clk = ~clk;

  avg_word_fmt u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .sampleChan(sampleChan), .statusFlags(statusFlags), .ratioCode(ratioCode),
    .fixPattern(fixPattern), .appendMode(appendMode), .outValid(outValid),
    .outWord(outWord), .outHasTag(outHasTag)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one sample for one cycle; record what the output shows next cycle
  task automatic sendSample(input logic [15:0] d, input logic [3:0] ch, input logic [3:0] st);
    sampleValid = 1'b1; sampleData = d; sampleChan = ch; statusFlags = st;
    @(negedge clk);
    sampleValid = 1'b0;
    gotValid = outValid; gotWord = outWord; gotTag = outHasTag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    check(outValid == 1'b0, "R9 reset valid", int'(outValid), 0);
    check(outWord == '0, "R9 reset word", int'(outWord), 0);
  endtask

  task automatic testPassThru();
    ratioCode = 3'd0; appendMode = 2'b00; idle(2);
    sendSample(16'h1234, 4'd3, 4'd0);
    check(gotValid, "R1 valid", int'(gotValid), 1);
    check(gotWord[19:4] == 16'h1234, "R1 data", int'(gotWord[19:4]), 'h1234);
    sendSample(16'hBEEF, 4'd1, 4'd0);
    check(gotWord[19:4] == 16'hBEEF, "R1 data2", int'(gotWord[19:4]), 'hBEEF);
    @(negedge clk);
    check(outValid == 1'b0, "R9 single pulse", int'(outValid), 0);
  endtask

  task automatic testAverage4();
    ratioCode = 3'd2; idle(2);
    sendSample(16'd10, 4'd0, 4'd0);
    check(!gotValid, "R2 no early out 1", int'(gotValid), 0);
    sendSample(16'd20, 4'd0, 4'd0);
    sendSample(16'd30, 4'd0, 4'd0);
    check(!gotValid, "R2 no early out 3", int'(gotValid), 0);
    sendSample(16'd41, 4'd0, 4'd0);
    check(gotValid, "R2 valid", int'(gotValid), 1);
    check(gotWord[19:4] == 16'd25, "R2 average", int'(gotWord[19:4]), 25);
  endtask

  task automatic testFullScale();
    ratioCode = 3'd7; idle(2);
    for (int i = 0; i < 127; i++) begin
      sendSample(16'hFFFF, 4'd0, 4'd0);
      if (gotValid) check(1'b0, "R3 early out", i, 127);
    end
    sendSample(16'hFFFF, 4'd0, 4'd0);
    check(gotValid, "R3 valid", int'(gotValid), 1);
    check(gotWord[19:4] == 16'hFFFF, "R3 full scale", int'(gotWord[19:4]), 'hFFFF);
  endtask

  task automatic testFixed();
    ratioCode = 3'd1; fixPattern = 1'b1; idle(2);
    sendSample(16'h0001, 4'd0, 4'd0);
    sendSample(16'h0003, 4'd0, 4'd0);
    check(gotValid && gotWord[19:4] == 16'hA5A5, "R4 pattern", int'(gotWord[19:4]), 'hA5A5);
    fixPattern = 1'b0;
    sendSample(16'h0001, 4'd0, 4'd0);
    sendSample(16'h0003, 4'd0, 4'd0);
    check(gotWord[19:4] == 16'h0002, "R4 pattern off", int'(gotWord[19:4]), 2);
  endtask

  task automatic testTags();
    ratioCode = 3'd1; appendMode = 2'b01; idle(2);
    sendSample(16'd4, 4'd2, 4'd9);
    sendSample(16'd6, 4'd7, 4'd5);
    check(gotTag && gotWord[3:0] == 4'd7, "R5 channel tag", int'(gotWord[3:0]), 7);
    check(gotWord[19:4] == 16'd5, "R5 data", int'(gotWord[19:4]), 5);
    appendMode = 2'b10;
    sendSample(16'd4, 4'd2, 4'd9);
    sendSample(16'd6, 4'd7, 4'hC);
    check(gotTag && gotWord[3:0] == 4'hC, "R6 status tag", int'(gotWord[3:0]), 'hC);
    appendMode = 2'b00;
    sendSample(16'd4, 4'd2, 4'd9);
    sendSample(16'd6, 4'd7, 4'hC);
    check(!gotTag && gotWord[3:0] == 4'd0, "R7 mode 00", int'(gotWord[3:0]), 0);
    appendMode = 2'b11;
    sendSample(16'd4, 4'd2, 4'd9);
    sendSample(16'd6, 4'd7, 4'hC);
    check(!gotTag && gotWord[3:0] == 4'd0, "R7 mode 11", int'(gotTag), 0);
    appendMode = 2'b00;
  endtask

  task automatic testRestart();
    ratioCode = 3'd3; idle(2);
    sendSample(16'd1000, 4'd0, 4'd0);
    sendSample(16'd1000, 4'd0, 4'd0);
    sendSample(16'd1000, 4'd0, 4'd0);
    ratioCode = 3'd1; idle(2);
    sendSample(16'd100, 4'd0, 4'd0);
    check(!gotValid, "R8 no out after first new", int'(gotValid), 0);
    sendSample(16'd201, 4'd0, 4'd0);
    check(gotValid, "R8 valid", int'(gotValid), 1);
    check(gotWord[19:4] == 16'd150, "R8 fresh average", int'(gotWord[19:4]), 150);
  endtask

  initial begin
    fork
      begin
        idle(3);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        testPassThru();
        testAverage4();
        testFullScale();
        testFixed();
        testTags();
        testRestart();
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule